// File: doc/BRIEF.md
# Key-Locked Flash Program Controller

This block guards the programming path of a small on-chip non-volatile array. The array is modelled here as a register array of 16-bit cells that start fully erased (all ones). Software reaches the controller through a small register bus with key, control and status registers. Stored data is read and programmed through a separate memory window. Programming is closed at reset. It opens only after two 32-bit key words arrive at the key register in the right order. Any other value written there closes the controller for good, and only a reset opens it again.

Once open, a program write can only pull bits from 1 to 0: the cell keeps the bitwise AND of its old contents and the written value. A write that arrives while the controller is locked, while a previous operation is still busy, or while an error flag is pending leaves the array untouched. Locked and busy attempts also raise sticky error flags, which software clears by writing ones. In strict mode only halfword program accesses are legal, and a byte or word access produces a one-cycle bus fault. A level interrupt reports the end of each program operation when it is enabled.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the control register reads with bit 31 (locked) set, the status register reads zero, irq is low and every cell reads 0xFFFF.
- R2: A program write made while locked leaves the array unchanged and sets status bit 2 (sequence error) and status bit 3 (parallelism error).
- R3: The controller unlocks only after register offset 0 receives KEY_A and then KEY_B as full-width writes (all four byte enables). After KEY_A alone, control bit 31 still reads 1. After both keys it reads 0.
- R4: Any key-register write outside that sequence, whether a wrong value or a partial byte enable, sets the hard lock (control bit 30). A correct key sequence does not clear the hard lock. Only a reset does.
- R5: Control bit 0 (interrupt enable) keeps its value on writes made while the controller is not unlocked.
- R6: An accepted halfword program (mem_size 1) stores the old cell value AND the written value.
- R7: While status bit 2 or bit 3 is set, an unlocked program write is rejected and the cell is unchanged. Writing ones to those status bits clears them, and programming then succeeds.
- R8: In strict mode, program writes with mem_size 0 (byte) or 2 (word) leave the array and the error flags unchanged, and raise bus_fault for the single cycle that follows the write.
- R9: An accepted program sets status bit 0 (busy) for BUSY_CYC cycles. A program write during busy sets the sequence error and does not change the array.
- R10: Status bit 1 (end of operation) is set when busy falls and is cleared by writing 1 to it. irq is high exactly while that bit and the interrupt enable are both set.
- R11: Writing 1 to control bit 31 (with byte enable 3) relocks an unlocked controller, and the full key sequence is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register offset: 0 key, 1 control, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Register byte enables |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_addr | input | $clog2(DEPTH) | Cell index in the memory window |
| mem_wdata | input | 32 | Program data |
| mem_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_we | input | 1 | Program write strobe |
| mem_rdata | output | 16 | Contents of the cell at mem_addr |
| bus_fault | output | 1 | One-cycle pulse after an illegal-size program write |
| irq | output | 1 | End-of-operation interrupt |

## Verification
Every cell is programmed twice with patterns derived from its index. Checking each result against the arithmetic AND separates a correct clear-only update from plain overwriting, from a write to the wrong cell, and from writes that leak into other cells. Program attempts are repeated in every guard condition: locked, hard-locked, busy, error pending, wrong size, and after a relock. A cell that stays at its known value in each case shows which gate is missing. The key register is driven with the correct pair, a lone first key, a wrong second word and a correct pair after a hard lock, which separates a real two-step sequence from a single-word compare or from a lock that a correct key can undo.

// File: rtl/nvmp_pkg.sv
package nvmp_pkg;
   localparam int CELL_W = 16;

   localparam logic [1:0] REG_KEY  = 2'd0;
   localparam logic [1:0] REG_CTRL = 2'd1;
   localparam logic [1:0] REG_STAT = 2'd2;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2,
      KS_HARD   = 2'd3
   } key_state_e;
endpackage

// File: rtl/nvmp_keylock.sv
module nvmp_keylock
   import nvmp_pkg::*;
#(
   parameter logic [31:0] KEY_A = 32'h4E56_1A2B,
   parameter logic [31:0] KEY_B = 32'hC3D4_E5F6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_we,
   input  logic        key_full,
   input  logic [31:0] key_val,
   input  logic        relock,
   output logic        unlocked,
   output logic        hard_locked
);
   key_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (key_we) begin
         unique case (state_q)
            KS_LOCKED: state_d = (key_full && key_val == KEY_A) ? KS_HALF : KS_HARD;
            KS_HALF:   state_d = (key_full && key_val == KEY_B) ? KS_OPEN : KS_HARD;
            default:   state_d = KS_HARD;
         endcase
      end else if (relock && state_q != KS_HARD) begin
         state_d = KS_LOCKED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KS_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked    = (state_q == KS_OPEN);
   assign hard_locked = (state_q == KS_HARD);
endmodule

// File: rtl/nvmp_busy.sv
module nvmp_busy #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (start)        cnt_q <= LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CW'(1)) && !start;
endmodule

// File: rtl/nvmp_array.sv
module nvmp_array
   import nvmp_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int STRICT = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        prog_en,
   input  logic [$clog2(DEPTH)-1:0]    prog_addr,
   input  logic [1:0]                  prog_size,
   input  logic [31:0]                 prog_data,
   input  logic [$clog2(DEPTH)-1:0]    rd_addr,
   output logic [CELL_W-1:0]           rd_data,
   output logic [DEPTH*CELL_W-1:0]     store_flat
);
   localparam int AW = $clog2(DEPTH);

   logic [CELL_W-1:0] cells [DEPTH];
   logic [CELL_W-1:0] lo_val, hi_val;
   logic              wr_lo, wr_hi;
   logic [AW-1:0]     hi_addr;

   assign hi_val  = prog_data[31:16];
   assign hi_addr = prog_addr + 1'b1;
   assign wr_lo   = prog_en;

   generate
      if (STRICT != 0) begin : g_strict
         assign lo_val = (prog_size == SZ_HALF) ? prog_data[15:0] : '1;
         assign wr_hi  = 1'b0;
      end else begin : g_relaxed
         assign lo_val = (prog_size == SZ_BYTE) ? {8'hFF, prog_data[7:0]} : prog_data[15:0];
         assign wr_hi  = prog_en && (prog_size == SZ_WORD);
      end
   endgenerate

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[g] <= '1;
         else if (wr_lo && prog_addr == AW'(g))
            cells[g] <= cells[g] & lo_val;
         else if (wr_hi && hi_addr == AW'(g))
            cells[g] <= cells[g] & hi_val;
      end
      assign store_flat[g*CELL_W +: CELL_W] = cells[g];
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
   import nvmp_pkg::*;
#(
   parameter int          DEPTH    = 16,
   parameter int          BUSY_CYC = 4,
   parameter int          STRICT   = 1,
   parameter logic [31:0] KEY_A    = 32'h4E56_1A2B,
   parameter logic [31:0] KEY_B    = 32'hC3D4_E5F6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               reg_addr,
   input  logic [31:0]              reg_wdata,
   input  logic [3:0]               reg_be,
   input  logic                     reg_we,
   output logic [31:0]              reg_rdata,
   input  logic [$clog2(DEPTH)-1:0] mem_addr,
   input  logic [31:0]              mem_wdata,
   input  logic [1:0]               mem_size,
   input  logic                     mem_we,
   output logic [15:0]              mem_rdata,
   output logic                     bus_fault,
   output logic                     irq
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least 1");
   end
   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("KEY_A and KEY_B must differ");
   end

   logic                    unlocked, hard_locked;
   logic                    busy, done;
   logic                    seq_err, par_err, eop, ien;
   logic                    size_ok, prog_try, accept;
   logic                    key_we, ctrl_we, stat_we, relock;
   logic [DEPTH*CELL_W-1:0] store_flat;

   assign key_we  = reg_we && reg_addr == REG_KEY;
   assign ctrl_we = reg_we && reg_addr == REG_CTRL;
   assign stat_we = reg_we && reg_addr == REG_STAT && reg_be[0];
   assign relock  = ctrl_we && reg_be[3] && reg_wdata[31];

   assign size_ok  = (STRICT != 0) ? (mem_size == SZ_HALF) : (mem_size != 2'd3);
   assign prog_try = mem_we && size_ok;
   assign accept   = prog_try && unlocked && !busy && !seq_err && !par_err;

   nvmp_keylock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) i_keylock (
      .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_full(&reg_be),
      .key_val(reg_wdata), .relock(relock),
      .unlocked(unlocked), .hard_locked(hard_locked)
   );

   nvmp_busy #(.CYC(BUSY_CYC)) i_busy (
      .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .done(done)
   );

   nvmp_array #(.DEPTH(DEPTH), .STRICT(STRICT)) i_array (
      .clk(clk), .rst_n(rst_n), .prog_en(accept), .prog_addr(mem_addr),
      .prog_size(mem_size), .prog_data(mem_wdata), .rd_addr(mem_addr),
      .rd_data(mem_rdata), .store_flat(store_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_err   <= 1'b0;
         par_err   <= 1'b0;
         eop       <= 1'b0;
         ien       <= 1'b0;
         bus_fault <= 1'b0;
      end else begin
         bus_fault <= mem_we && !size_ok;
         if (prog_try && (!unlocked || busy)) seq_err <= 1'b1;
         else if (stat_we && reg_wdata[2])    seq_err <= 1'b0;
         if (prog_try && !unlocked)           par_err <= 1'b1;
         else if (stat_we && reg_wdata[3])    par_err <= 1'b0;
         if (done)                            eop <= 1'b1;
         else if (stat_we && reg_wdata[1])    eop <= 1'b0;
         if (ctrl_we && reg_be[0] && unlocked) ien <= reg_wdata[0];
      end
   end

   assign irq = eop && ien;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         REG_CTRL: reg_rdata = {!unlocked, hard_locked, 29'd0, ien};
         REG_STAT: reg_rdata = {28'd0, par_err, seq_err, eop, busy};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/nvmp_checker.sv
module nvmp_checker #(
   parameter int DEPTH  = 16,
   parameter int STRICT = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mem_we,
   input logic [1:0]          mem_size,
   input logic                bus_fault,
   input logic [DEPTH*16-1:0] store_flat,
   input logic                unlocked,
   input logic                hard_locked,
   input logic                busy,
   input logic                seq_err,
   input logic                par_err,
   input logic                eop,
   input logic                ien
);
   a_r2_locked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_size == 2'd1 && !unlocked) |=> $stable(store_flat));

   a_r2_locked_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_size == 2'd1 && !unlocked) |=> (seq_err && par_err));

   a_r4_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      hard_locked |=> hard_locked);

   a_r5_ien_guard: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(ien));

   a_r6_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((store_flat & ~$past(store_flat)) == '0));

   a_r9_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_size == 2'd1 && busy) |=> seq_err);

   a_r10_eop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> eop);

   if (STRICT != 0) begin : g_strict_chk
      a_r8_size_fault: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_we && mem_size != 2'd1) |=> (bus_fault && $stable(store_flat)));
   end
endmodule

bind nvm_prog_ctrl nvmp_checker #(.DEPTH(DEPTH), .STRICT(STRICT)) i_nvmp_checker (.*);

// File: tb/test_nvm_prog_ctrl.sv
module test_nvm_prog_ctrl;
   localparam int          DEPTH = 16;
   localparam int          BUSY  = 4;
   localparam logic [31:0] KA    = 32'h4E56_1A2B;
   localparam logic [31:0] KB    = 32'hC3D4_E5F6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  reg_be = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic [3:0]  mem_addr = '0;
   logic [31:0] mem_wdata = '0;
   logic [1:0]  mem_size = 2'd1;
   logic        mem_we = 1'b0;
   logic [15:0] mem_rdata;
   logic        bus_fault, irq;

   int          n_cmp = 0;
   int          n_bad = 0;
   bit          finished = 0;
   logic [15:0] model [DEPTH];

   always #2 clk = ~clk;

   nvm_prog_ctrl #(.DEPTH(DEPTH), .BUSY_CYC(BUSY), .STRICT(1), .KEY_A(KA), .KEY_B(KB)) i_nvm_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_be(reg_be), .reg_we(reg_we), .reg_rdata(reg_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_size(mem_size),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .bus_fault(bus_fault), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
   endtask

   task automatic reg_wr(logic [1:0] a, logic [31:0] d, logic [3:0] be);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_be = be; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic mem_prog(logic [3:0] a, logic [31:0] d, logic [1:0] sz);
      @(negedge clk);
      mem_addr = a; mem_wdata = d; mem_size = sz; mem_we = 1'b1;
      @(negedge clk);
      mem_we = 1'b0;
   endtask

   task automatic mem_rd(logic [3:0] a, output logic [15:0] d);
      mem_addr = a;
      #0.5;
      d = mem_rdata;
   endtask

   task automatic idle();
      repeat (BUSY + 2) @(negedge clk);
   endtask

   task automatic unlock();
      reg_wr(2'd0, KA, 4'hF);
      reg_wr(2'd0, KB, 4'hF);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [15:0] m;
      logic [15:0] p1, p2;

      do_reset();
      // R1 reset state
      reg_rd(2'd1, r); chk("R1 ctrl", r, 32'h8000_0000);
      reg_rd(2'd2, r); chk("R1 status", r, 32'h0);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      for (int i = 0; i < DEPTH; i++) begin
         mem_rd(4'(i), m); chk("R1 erased cell", {16'd0, m}, 32'h0000_FFFF);
      end

      // R2 locked program
      mem_prog(4'd3, 32'h0, 2'd1);
      mem_rd(4'd3, m); chk("R2 locked cell", {16'd0, m}, 32'h0000_FFFF);
      reg_rd(2'd2, r); chk("R2 error flags", r, 32'h0000_000C);

      // R5 interrupt enable guarded while locked
      reg_wr(2'd1, 32'h1, 4'h1);
      reg_rd(2'd1, r); chk("R5 ien locked", r, 32'h8000_0000);

      // R3 two-step unlock
      reg_wr(2'd0, KA, 4'hF);
      reg_rd(2'd1, r); chk("R3 half key", r, 32'h8000_0000);
      reg_wr(2'd0, KB, 4'hF);
      reg_rd(2'd1, r); chk("R3 unlocked", r, 32'h0);

      // R7 errors pending block programming
      mem_prog(4'd3, 32'h0, 2'd1);
      idle();
      mem_rd(4'd3, m); chk("R7 rejected", {16'd0, m}, 32'h0000_FFFF);
      reg_wr(2'd2, 32'hC, 4'h1);
      reg_rd(2'd2, r); chk("R7 cleared", r, 32'h0);

      // R9 busy duration, R10 end of operation
      reg_wr(2'd1, 32'h1, 4'h1);
      reg_rd(2'd1, r); chk("R5 ien unlocked", r, 32'h1);
      mem_prog(4'd3, 32'h0000_F0F0, 2'd1);
      model[3] = 16'hF0F0;
      for (int c = 0; c < BUSY; c++) begin
         reg_rd(2'd2, r); chk("R9 busy high", r, 32'h1);
         @(negedge clk);
      end
      reg_rd(2'd2, r); chk("R10 eop after busy", r, 32'h2);
      chk("R10 irq", {31'd0, irq}, 32'd1);
      reg_wr(2'd2, 32'h2, 4'h1);
      chk("R10 irq cleared", {31'd0, irq}, 32'd0);
      reg_wr(2'd1, 32'h0, 4'h1);
      mem_rd(4'd3, m); chk("R6 first program", {16'd0, m}, {16'd0, model[3]});

      // R6 sweep: two patterns per cell
      for (int i = 0; i < DEPTH; i++) begin
         p1 = 16'(i * 16'h1111) ^ 16'hA5C3;
         p2 = ~16'(i << (i % 12));
         mem_prog(4'(i), {16'hDEAD, p1}, 2'd1); idle();
         model[i] = model[i] & p1;
         mem_prog(4'(i), {16'hBEEF, p2}, 2'd1); idle();
         model[i] = model[i] & p2;
      end
      for (int i = 0; i < DEPTH; i++) begin
         mem_rd(4'(i), m); chk("R6 AND result", {16'd0, m}, {16'd0, model[i]});
      end
      reg_wr(2'd2, 32'h2, 4'h1);

      // R9 write during busy
      mem_prog(4'd5, 32'h0, 2'd1);
      model[5] = 16'h0;
      mem_prog(4'd6, 32'h0, 2'd1);
      idle();
      mem_rd(4'd6, m); chk("R9 busy write dropped", {16'd0, m}, {16'd0, model[6]});
      reg_rd(2'd2, r); chk("R9 seq error", r, 32'h6);
      reg_wr(2'd2, 32'h6, 4'h1);

      // R8 strict size faults
      mem_prog(4'd2, 32'h0, 2'd0);
      chk("R8 byte fault", {31'd0, bus_fault}, 32'd1);
      @(negedge clk);
      chk("R8 fault one cycle", {31'd0, bus_fault}, 32'd0);
      mem_prog(4'd2, 32'h0, 2'd2);
      chk("R8 word fault", {31'd0, bus_fault}, 32'd1);
      mem_rd(4'd2, m); chk("R8 cell kept", {16'd0, m}, {16'd0, model[2]});
      reg_rd(2'd2, r); chk("R8 no flags", r, 32'h0);

      // R11 relock
      reg_wr(2'd1, 32'h8000_0000, 4'h8);
      reg_rd(2'd1, r); chk("R11 relocked", r, 32'h8000_0000);
      mem_prog(4'd7, 32'h0, 2'd1);
      mem_rd(4'd7, m); chk("R11 locked cell", {16'd0, m}, {16'd0, model[7]});
      reg_wr(2'd2, 32'hC, 4'h1);
      unlock();
      reg_rd(2'd1, r); chk("R11 unlock again", r, 32'h0);

      // R4 hard lock
      do_reset();
      reg_wr(2'd0, KA, 4'hF);
      reg_wr(2'd0, 32'h1234_5678, 4'hF);
      reg_rd(2'd1, r); chk("R4 hard lock", r, 32'hC000_0000);
      unlock();
      reg_rd(2'd1, r); chk("R4 keys ignored", r, 32'hC000_0000);
      do_reset();
      reg_wr(2'd0, KA, 4'h7);
      reg_rd(2'd1, r); chk("R4 partial be", r, 32'hC000_0000);
      do_reset();
      unlock();
      reg_rd(2'd1, r); chk("R4 reset clears", r, 32'h0);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule